// File: doc/BRIEF.md
# Feed-Protected PLL Control Register Bank

This block is the software-facing control point for a clock-multiplying PLL. Software writes the desired multiplier, divider, enable and connect settings into holding registers over a simple synchronous write/read bus. These writes have no effect on the PLL until software commits them with a two-write unlock sequence on a dedicated feed address. A stray write therefore cannot retune or switch off the clock that the rest of the chip runs from.

Only the active (shadow) copy drives the PLL. The block outputs the multiplier code, the divider code, the enable bit and a clock-select signal. The select signal picks the PLL output over the raw oscillator only when the active enable and the active connect bits are both set. A cycle counter models lock acquisition. A power-down input drops the PLL back to the oscillator. A status address reads back the values in force, not the pending ones.

Top module: `pll_feed_regs`

## Requirements
- R1: The address map is: 0 = control holding register (bit 0 enable, bit 1 connect); 1 = configuration holding register (bits 4:0 multiplier code M-1 for M = 1..32; bits 6:5 divider code, where 00, 01, 10 and 11 select P = 1, 2, 4 and 8); 2 = status; 3 = feed. Reading address 0 or 1 returns the holding value. Reading address 3 returns zero.
- R2: A write to the control or configuration register changes none of `mul_code`, `div_code`, `pll_en`, `clk_sel_pll` or the status word.
- R3: A write of 0x00AA to the feed address, followed by the next bus write being 0x0055 to the feed address, copies both holding registers into the active registers on the clock edge of the 0x0055 write. The whole 16-bit word is compared.
- R4: The sequence is aborted by any other feed value after 0x00AA, by a write to another address in between, or by a 0x0055 that has no 0x00AA before it. In each case nothing is loaded. A repeated 0x00AA re-arms the sequence.
- R5: Reading address 2 returns the active multiplier code in bits 4:0, the active divider code in bits 6:5, the active enable in bit 8, the active connect in bit 9 and the lock flag in bit 10. `mul_code` and `div_code` present the active codes, including the extremes 31 (M=32) and 3 (P=8).
- R6: `clk_sel_pll` is 1 exactly when the active enable and the active connect are both 1. Otherwise the oscillator is selected.
- R7: The lock flag clears on the edge where the active enable rises or the active configuration changes. It sets LOCK_CYCLES edges later. Reloading an unchanged configuration with the enable kept on leaves the lock set.
- R8: While `pwr_down` is high, the active enable, the active connect and the lock flag are cleared at the next edge. The active configuration and the holding registers are kept.
- R9: Reset clears the holding registers, the active registers, the feed state and the lock flag. The oscillator is then selected.
- R10: Bits that are not listed in R1 and R5 read as zero, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Register address for writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| pwr_down | input | 1 | Power-down request |
| mul_code | output | 5 | Active multiplier code (M-1) |
| div_code | output | 2 | Active divider code |
| pll_en | output | 1 | Active PLL enable |
| clk_sel_pll | output | 1 | 1 selects the PLL clock, 0 the oscillator |
| locked | output | 1 | Modelled lock flag |

## Verification
A write is captured on the rising edge after it is driven. Holding readback and the active outputs after a 0x0055 feed write are therefore due one edge after the write. Power-down clears the outputs one edge after it is raised. The lock flag is due exactly LOCK_CYCLES edges after the edge that committed the enable or the new configuration. The bench drives on falling edges and samples on falling edges. It checks the lock flag one falling edge before it is due (still 0) and on the falling edge where it is due (1), so an off-by-one in the counter is caught.

// File: rtl/pll_feed_regs.sv
module pll_feed_regs #(
  parameter int          ADDR_W      = 2,
  parameter int          DATA_W      = 16,
  parameter int          LOCK_CYCLES = 64,
  parameter logic [7:0]  FEED_KEY1   = 8'hAA,
  parameter logic [7:0]  FEED_KEY2   = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pwr_down,
  output logic [4:0]        mul_code,
  output logic [1:0]        div_code,
  output logic              pll_en,
  output logic              clk_sel_pll,
  output logic              locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(3);

  logic [1:0]       hold_ctrl;
  logic [6:0]       hold_cfg, act_cfg, next_cfg;
  logic             act_en, act_con, next_en, next_con;
  logic             armed, lock_q, restart;
  logic [CNT_W-1:0] cnt;

  wire feed_wr = wr_en && (addr == A_FEED);
  wire key1    = feed_wr && (wdata == DATA_W'(FEED_KEY1));
  wire commit  = feed_wr && armed && (wdata == DATA_W'(FEED_KEY2));

  assign next_cfg = commit ? hold_cfg : act_cfg;
  assign next_en  = !pwr_down && (commit ? hold_ctrl[0] : act_en);
  assign next_con = !pwr_down && (commit ? hold_ctrl[1] : act_con);
  assign restart  = next_en && (!act_en || (next_cfg != act_cfg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ctrl <= '0;
      hold_cfg  <= '0;
      act_cfg   <= '0;
      act_en    <= 1'b0;
      act_con   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) hold_ctrl <= wdata[1:0];
      if (wr_en && addr == A_CFG)  hold_cfg  <= wdata[6:0];
      if (wr_en) armed <= key1;
      act_cfg <= next_cfg;
      act_en  <= next_en;
      act_con <= next_con;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lock_q <= 1'b0;
    end else if (!next_en || restart) begin
      cnt    <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (cnt == CNT_W'(LOCK_CYCLES - 1)) lock_q <= 1'b1;
      else                                 cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1:0]  = hold_ctrl;
      A_CFG:   rdata[6:0]  = hold_cfg;
      A_STAT:  rdata[10:0] = {lock_q, act_con, act_en, 1'b0, act_cfg};
      default: rdata = '0;
    endcase
  end

  assign mul_code    = act_cfg[4:0];
  assign div_code    = act_cfg[6:5];
  assign pll_en      = act_en;
  assign clk_sel_pll = act_en && act_con;
  assign locked      = lock_q;
endmodule

// File: rtl/pll_feed_regs_chk.sv
module pll_feed_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              pwr_down,
  input logic [4:0]        mul_code,
  input logic [1:0]        div_code,
  input logic              pll_en,
  input logic              clk_sel_pll,
  input logic              locked
);
  // R2 R3
  cfg_change_needs_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mul_code, div_code}) |->
      $past(wr_en && addr == ADDR_W'(3) && wdata == DATA_W'(16'h0055)));

  // R3
  en_rise_needs_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(wr_en && addr == ADDR_W'(3) && wdata == DATA_W'(16'h0055)));

  // R6
  sel_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_pll |-> pll_en);

  // R7
  lock_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> pll_en);

  // R7
  lock_low_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !locked);

  // R8
  pwr_down_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !pll_en && !clk_sel_pll && !locked);

  // R10
  status_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(2) |-> rdata[7] == 1'b0 && rdata[DATA_W-1:11] == '0);
endmodule

bind pll_feed_regs pll_feed_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pwr_down(pwr_down), .mul_code(mul_code), .div_code(div_code),
  .pll_en(pll_en), .clk_sel_pll(clk_sel_pll), .locked(locked)
);

// File: tb/tb_pll_feed_regs.sv
module tb_pll_feed_regs;
  localparam int L = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwr_down = 1'b0;
  logic [4:0]  mul_code;
  logic [1:0]  div_code;
  logic        pll_en, clk_sel_pll, locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_feed_regs #(.LOCK_CYCLES(L)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_down(pwr_down), .mul_code(mul_code), .div_code(div_code),
    .pll_en(pll_en), .clk_sel_pll(clk_sel_pll), .locked(locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd2; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
    addr = 2'd2;
  endtask

  task automatic feed();
    wr(2'd3, 16'h00AA);
    wr(2'd3, 16'h0055);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R9 ctrl after reset", v, 0);
    rd(2'd1, v); chk("R9 cfg after reset", v, 0);
    rd(2'd2, v); chk("R9 status after reset", v, 0);
    chk("R9 outputs after reset", {mul_code, div_code, pll_en, clk_sel_pll, locked}, 0);
  endtask

  task automatic t_holding();
    logic [15:0] v;
    wr(2'd1, 16'h0023);
    wr(2'd0, 16'h0001);
    rd(2'd1, v); chk("R1 cfg holding readback", v, 16'h0023);
    rd(2'd0, v); chk("R1 ctrl holding readback", v, 16'h0001);
    rd(2'd3, v); chk("R1 feed reads zero", v, 0);
    rd(2'd2, v); chk("R2 status unchanged by holding writes", v, 0);
    chk("R2 outputs unchanged by holding writes", {mul_code, div_code, pll_en, clk_sel_pll}, 0);
  endtask

  task automatic t_feed_and_lock();
    logic [15:0] v;
    feed();
    chk("R3 mul_code after feed", mul_code, 3);
    chk("R3 div_code after feed", div_code, 1);
    chk("R6 oscillator kept without connect", clk_sel_pll, 0);
    rd(2'd2, v); chk("R5 status after feed", v, 16'h0123);
    repeat (L - 1) @(negedge clk);
    chk("R7 not locked one cycle early", locked, 0);
    @(negedge clk);
    chk("R7 locked after LOCK_CYCLES", locked, 1);
    rd(2'd2, v); chk("R5 status lock bit", v, 16'h0523);
  endtask

  task automatic t_connect();
    wr(2'd0, 16'h0003);
    chk("R2 connect waits for feed", clk_sel_pll, 0);
    feed();
    chk("R6 PLL selected with enable and connect", clk_sel_pll, 1);
    chk("R7 lock kept on unchanged reload", locked, 1);
  endtask

  task automatic t_abort();
    wr(2'd1, 16'h0004);
    wr(2'd3, 16'h00AA); wr(2'd0, 16'h0003); wr(2'd3, 16'h0055);
    chk("R4 other write aborts", mul_code, 3);
    wr(2'd3, 16'h00AA); wr(2'd3, 16'h0012); wr(2'd3, 16'h0055);
    chk("R4 wrong key aborts", mul_code, 3);
    wr(2'd3, 16'h0055);
    chk("R4 lone second key ignored", mul_code, 3);
    wr(2'd3, 16'h01AA); wr(2'd3, 16'h0055);
    chk("R3 full word compared", mul_code, 3);
    wr(2'd3, 16'h00AA); feed();
    chk("R4 repeated first key re-arms", mul_code, 4);
    chk("R7 reconfig clears lock", locked, 0);
    repeat (L - 1) @(negedge clk);
    chk("R7 relock not early", locked, 0);
    @(negedge clk);
    chk("R7 relock on time", locked, 1);
  endtask

  task automatic t_pwr_down();
    logic [15:0] v;
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk); pwr_down = 1'b0;
    chk("R8 power-down clears enable/select/lock", {pll_en, clk_sel_pll, locked}, 0);
    chk("R8 power-down keeps config", {mul_code, div_code}, {5'd4, 2'd0});
    rd(2'd0, v); chk("R8 power-down keeps holding", v, 16'h0003);
    feed();
    chk("R6 re-enabled after feed", {pll_en, clk_sel_pll, locked}, 3'b110);
  endtask

  task automatic t_bounds_reserved();
    logic [15:0] v;
    wr(2'd1, 16'h007F);
    feed();
    chk("R5 M=32 code", mul_code, 31);
    chk("R5 P=8 code", div_code, 3);
    rd(2'd2, v); chk("R5 status extremes", v, 16'h037F);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R10 ctrl reserved bits", v, 16'h0003);
    wr(2'd1, 16'hFF81);
    rd(2'd1, v); chk("R10 cfg reserved bits", v, 16'h0001);
    chk("R2 config write kept in holding", mul_code, 31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_holding();
    t_feed_and_lock();
    t_connect();
    t_abort();
    t_pwr_down();
    t_bounds_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule